// File: doc/BRIEF.md
# Keyed-Control Watchdog Counter

This block is a 32-bit up-counting watchdog timer that a processor controls through a small word-addressed register port. The timer starts or stops only when software writes two fixed 16-bit key words, in the right order, to a dedicated key register. A single stray write therefore cannot stop a running watchdog. Only the low 16 bits of each key write are compared.

The counter advances either on every clock or once every 2^(ratio+1) clocks, as set by a prescaler. When it passes all-ones it reloads from the load register and sets an overflow status flag. Software can stage a new load value and a new prescale setting at any time. The counter picks them up only at its next overflow, or when software writes a fresh value to the trigger register.

An active-low interrupt line asserts whenever both the status flag and its enable bit are set, whichever of the two was set first. A freeze input lets a debug halt stop the count, unless a free-run bit in the control register says to keep counting. The bus side and the counter share one clock.

Top module: `kwd_wdog`

## Requirements
- R1: After synchronous reset the count (address 2) reads 0, the run flag (address 7, bit 0) reads 0, the load register (address 1) reads 0, status and enable read 0, and irq_n is 1.
- R2: Two writes to the key register (address 4) start the timer: the first has low half 0xBBBB and the second has low half 0x4444. Two writes with low halves 0xAAAA then 0x5555 stop it. The upper 16 bits of each key write are ignored.
- R3: Any other sequence of key writes leaves the run flag unchanged. This includes a second word written alone, and a non-key word written between the first and second words of a pair.
- R4: While running with prescaling off, the count rises by one on every clock. While stopped, the count holds.
- R5: The control register (address 0) has prescale enable at bit 1 and ratio at bits [4:2]. With prescaling on, the count advances once every 2^(ratio+1) clocks.
- R6: When the count passes 0xFFFFFFFF, it reloads from the load register and sets status bit 0 (address 5).
- R7: Writes to the load and control registers read back at once. The counter uses a new load value or prescale setting only at the next overflow or trigger.
- R8: A write to the trigger register (address 3) whose value differs from the last value written there reloads the count from the load register at once and applies the staged prescale setting. Writing the same value again changes nothing.
- R9: irq_n goes to 0 one clock after status and enable (address 6, bit 0) are both 1, whichever was set first. It returns to 1 one clock after either bit clears.
- R10: Writing 1 to status bit 0 clears it. Writing 0 has no effect, so writing back the value that was read acknowledges the interrupt. If an overflow and a clear land on the same clock, the overflow wins.
- R11: While emu_halt is 1 and control bit 5 is 0, the count freezes. When control bit 5 is 1, the count keeps running.
- R12: A read strobe returns the addressed register on bus_rdata one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the bus side and the counter |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_addr | input | 3 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| emu_halt | input | 1 | Debug halt request |
| irq_n | output | 1 | Active-low overflow interrupt |

## Verification
A key write changes the run flag on the clock edge that takes the second word. The counter first moves on the following edge, and it still moves on the edge that takes the second stop word. A run bracketed by N idle clocks therefore gives N+2 counter edges, or floor((N+2)/2^(ratio+1)) with prescaling on. The bench waits for these counts and then reads the frozen count back through the bus. Read data arrives one clock after the strobe. irq_n trails the status or enable change by one clock, so every interrupt check is sampled at least one full clock after the write or overflow that causes it.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
  localparam int unsigned KEY_W = 16;

  localparam logic [2:0] A_CTRL  = 3'd0;
  localparam logic [2:0] A_LOAD  = 3'd1;
  localparam logic [2:0] A_COUNT = 3'd2;
  localparam logic [2:0] A_TRIG  = 3'd3;
  localparam logic [2:0] A_KEY   = 3'd4;
  localparam logic [2:0] A_STAT  = 3'd5;
  localparam logic [2:0] A_IEN   = 3'd6;
  localparam logic [2:0] A_RUN   = 3'd7;

  localparam logic [KEY_W-1:0] KEY_ON_1  = 16'hBBBB;
  localparam logic [KEY_W-1:0] KEY_ON_2  = 16'h4444;
  localparam logic [KEY_W-1:0] KEY_OFF_1 = 16'hAAAA;
  localparam logic [KEY_W-1:0] KEY_OFF_2 = 16'h5555;

  typedef enum logic [1:0] {
    KS_IDLE    = 2'd0,
    KS_ARM_ON  = 2'd1,
    KS_ARM_OFF = 2'd2
  } key_state_t;
endpackage

// File: rtl/kwd_keyseq.sv
module kwd_keyseq
  import kwd_pkg::*;
#(
  parameter int unsigned WORD_W = KEY_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              key_wr,
  input  logic [WORD_W-1:0] key_word,
  output logic              run_q
);
  key_state_t state_q;
  key_state_t state_d;
  logic       run_d;

  // A first word always re-arms; anything else falls back to idle.
  function automatic key_state_t arm_of(input logic [WORD_W-1:0] w);
    if (w == KEY_ON_1)       return KS_ARM_ON;
    else if (w == KEY_OFF_1) return KS_ARM_OFF;
    else                     return KS_IDLE;
  endfunction

  always_comb begin
    state_d = state_q;
    run_d   = run_q;
    if (key_wr) begin
      unique case (state_q)
        KS_ARM_ON: begin
          if (key_word == KEY_ON_2) begin
            run_d   = 1'b1;
            state_d = KS_IDLE;
          end else begin
            state_d = arm_of(key_word);
          end
        end
        KS_ARM_OFF: begin
          if (key_word == KEY_OFF_2) begin
            run_d   = 1'b0;
            state_d = KS_IDLE;
          end else begin
            state_d = arm_of(key_word);
          end
        end
        default: state_d = arm_of(key_word);
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= KS_IDLE;
      run_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      run_q   <= run_d;
    end
  end

  // R3
  run_needs_key_chk: assert property (@(posedge clk) disable iff (rst)
    (run_q != $past(run_q)) |-> $past(key_wr));

  // R2
  start_word_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(run_q) |-> ($past(key_word) == KEY_ON_2));

  // R2
  stop_word_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(run_q) |-> ($past(key_word) == KEY_OFF_2));
endmodule

// File: rtl/kwd_prescale.sv
module kwd_prescale #(
  parameter int unsigned PTV_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             adv,
  input  logic             pre_en,
  input  logic [PTV_W-1:0] ptv,
  output logic             tick
);
  localparam int unsigned DIV_W = 1 << PTV_W;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] div_mask;
  logic             at_end;

  // Terminal value is 2^(ptv+1)-1; a shift past the top wraps to all ones.
  assign div_mask = (DIV_W'(1) << ({1'b0, ptv} + 1'b1)) - DIV_W'(1);
  assign at_end   = (div_q == div_mask);
  assign tick     = adv && (!pre_en || at_end);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      div_q <= '0;
    end else if (adv && pre_en) begin
      div_q <= at_end ? '0 : div_q + 1'b1;
    end
  end

  // R5
  no_back_to_back_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && pre_en) |=> (!tick || !pre_en));

  // R11
  tick_needs_adv_chk: assert property (@(posedge clk) disable iff (rst)
    tick |-> adv);
endmodule

// File: rtl/kwd_counter.sv
module kwd_counter #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PTV_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              trig,
  input  logic [DATA_W-1:0] stage_load,
  input  logic              stage_pre_en,
  input  logic [PTV_W-1:0]  stage_ptv,
  output logic [DATA_W-1:0] cnt_q,
  output logic              act_pre_en,
  output logic [PTV_W-1:0]  act_ptv,
  output logic              ovf
);
  assign ovf = tick && (cnt_q == {DATA_W{1'b1}});

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= '0;
      act_pre_en <= 1'b0;
      act_ptv    <= '0;
    end else if (trig || ovf) begin
      cnt_q      <= stage_load;
      act_pre_en <= stage_pre_en;
      act_ptv    <= stage_ptv;
    end else if (tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R4
  count_moves_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != $past(cnt_q)) |-> $past(tick || trig));

  // R6
  wrap_reload_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf && !trig) |=> (cnt_q == $past(stage_load)));

  // R7
  prescale_held_chk: assert property (@(posedge clk) disable iff (rst)
    !(trig || ovf) |=> $stable(act_ptv) && $stable(act_pre_en));
endmodule

// File: rtl/kwd_wdog.sv
module kwd_wdog
  import kwd_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned PTV_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              emu_halt,
  output logic              irq_n
);
  localparam int unsigned PRE_EN_BIT = 1;
  localparam int unsigned PTV_LSB    = 2;
  localparam int unsigned FREE_BIT   = PTV_LSB + PTV_W;

  logic              ctl_pre_en;
  logic [PTV_W-1:0]  ctl_ptv;
  logic              ctl_free;
  logic [DATA_W-1:0] load_q;
  logic [DATA_W-1:0] trig_q;
  logic              stat_q;
  logic              ien_q;
  logic [DATA_W-1:0] rdata_q;
  logic              irq_n_q;

  logic              run_q;
  logic              adv;
  logic              tick;
  logic              ovf;
  logic              trig_hit;
  logic [DATA_W-1:0] cnt_q;
  logic              act_pre_en;
  logic [PTV_W-1:0]  act_ptv;
  logic [DATA_W-1:0] ctl_view;

  logic wr_ctrl, wr_load, wr_trig, wr_key, wr_stat, wr_ien;

  assign wr_ctrl  = bus_we && (bus_addr == A_CTRL);
  assign wr_load  = bus_we && (bus_addr == A_LOAD);
  assign wr_trig  = bus_we && (bus_addr == A_TRIG);
  assign wr_key   = bus_we && (bus_addr == A_KEY);
  assign wr_stat  = bus_we && (bus_addr == A_STAT);
  assign wr_ien   = bus_we && (bus_addr == A_IEN);
  assign trig_hit = wr_trig && (bus_wdata != trig_q);
  assign adv      = run_q && !(emu_halt && !ctl_free);

  kwd_keyseq #(.WORD_W(KEY_W)) u_keyseq (
    .clk      (clk),
    .rst      (rst),
    .key_wr   (wr_key),
    .key_word (bus_wdata[KEY_W-1:0]),
    .run_q    (run_q)
  );

  kwd_prescale #(.PTV_W(PTV_W)) u_prescale (
    .clk    (clk),
    .rst    (rst),
    .clr    (trig_hit),
    .adv    (adv),
    .pre_en (act_pre_en),
    .ptv    (act_ptv),
    .tick   (tick)
  );

  kwd_counter #(.DATA_W(DATA_W), .PTV_W(PTV_W)) u_counter (
    .clk          (clk),
    .rst          (rst),
    .tick         (tick),
    .trig         (trig_hit),
    .stage_load   (load_q),
    .stage_pre_en (ctl_pre_en),
    .stage_ptv    (ctl_ptv),
    .cnt_q        (cnt_q),
    .act_pre_en   (act_pre_en),
    .act_ptv      (act_ptv),
    .ovf          (ovf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_pre_en <= 1'b0;
      ctl_ptv    <= '0;
      ctl_free   <= 1'b0;
      load_q     <= '0;
      trig_q     <= '0;
      ien_q      <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ctl_pre_en <= bus_wdata[PRE_EN_BIT];
        ctl_ptv    <= bus_wdata[PTV_LSB +: PTV_W];
        ctl_free   <= bus_wdata[FREE_BIT];
      end
      if (wr_load) load_q <= bus_wdata;
      if (wr_trig) trig_q <= bus_wdata;
      if (wr_ien)  ien_q  <= bus_wdata[0];
    end
  end

  // Overflow outranks a same-cycle clear.
  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= 1'b0;
    end else if (ovf) begin
      stat_q <= 1'b1;
    end else if (wr_stat && bus_wdata[0]) begin
      stat_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_n_q <= 1'b1;
    else     irq_n_q <= !(stat_q && ien_q);
  end

  always_comb begin
    ctl_view                        = '0;
    ctl_view[PRE_EN_BIT]            = ctl_pre_en;
    ctl_view[PTV_LSB +: PTV_W]      = ctl_ptv;
    ctl_view[FREE_BIT]              = ctl_free;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (bus_re) begin
      unique case (bus_addr)
        A_CTRL:  rdata_q <= ctl_view;
        A_LOAD:  rdata_q <= load_q;
        A_COUNT: rdata_q <= cnt_q;
        A_TRIG:  rdata_q <= trig_q;
        A_STAT:  rdata_q <= DATA_W'(stat_q);
        A_IEN:   rdata_q <= DATA_W'(ien_q);
        A_RUN:   rdata_q <= DATA_W'(run_q);
        default: rdata_q <= '0;
      endcase
    end
  end

  assign bus_rdata = rdata_q;
  assign irq_n     = irq_n_q;

  // R9
  irq_follows_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_q && ien_q) |=> !irq_n);

  // R9
  irq_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !(stat_q && ien_q) |=> irq_n);

  // R6
  stat_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(stat_q) |-> $past(ovf));

  // R10
  stat_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(stat_q) |-> $past(wr_stat && bus_wdata[0] && !ovf));
endmodule

// File: tb/kwd_wdog_bench.sv
module kwd_wdog_bench;
  import kwd_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        emu_halt = 1'b0;
  logic        irq_n;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  logic [31:0] trig_val = 32'd0;

  always #(CLK_PERIOD/2) clk = ~clk;

  kwd_wdog u_kwd_wdog (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .emu_halt(emu_halt), .irq_n(irq_n)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == WATCHDOG) begin
      fails  = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected fewer)", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_re = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start_t(); wr(A_KEY, 32'h0000BBBB); wr(A_KEY, 32'h00004444); endtask
  task automatic stop_t();  wr(A_KEY, 32'h0000AAAA); wr(A_KEY, 32'h00005555); endtask

  task automatic fire_trig();
    trig_val = trig_val + 1;
    wr(A_TRIG, trig_val);
  endtask

  // Counter edges between start and stop with n idle clocks in between.
  function automatic logic [31:0] run_edges(input int n, input bit pre, input int ptv);
    int e = n + 2;
    return pre ? 32'(e >> (ptv + 1)) : 32'(e);
  endfunction

  function automatic logic [15:0] junk_word();
    logic [15:0] w;
    do w = 16'($urandom); while (w == 16'hBBBB || w == 16'h4444 ||
                                 w == 16'hAAAA || w == 16'h5555);
    return w;
  endfunction

  initial begin
    logic [31:0] v;
    void'($urandom(32'd2024));
    idle(3);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    rd(A_COUNT, v); check("R1 count", v, 0);
    rd(A_RUN, v);   check("R1 run", v, 0);
    rd(A_LOAD, v);  check("R1 load", v, 0);
    rd(A_STAT, v);  check("R1 stat", v, 0);
    rd(A_IEN, v);   check("R1 ien", v, 0);
    check("R1 irq_n", 32'(irq_n), 1);

    // R3 broken and partial key sequences
    wr(A_KEY, 32'h00004444);
    rd(A_RUN, v); check("R3 lone second word", v, 0);
    for (int i = 0; i < 6; i++) begin
      wr(A_KEY, 32'h0000BBBB); wr(A_KEY, {16'h0, junk_word()}); wr(A_KEY, 32'h00004444);
      rd(A_RUN, v); check("R3 interrupted start", v, 0);
    end

    // R2 upper half ignored
    wr(A_KEY, 32'hDEADBBBB); wr(A_KEY, 32'h77774444);
    rd(A_RUN, v); check("R2 start", v, 1);
    for (int i = 0; i < 4; i++) begin
      wr(A_KEY, 32'h0000AAAA); wr(A_KEY, {16'h0, junk_word()}); wr(A_KEY, 32'h00005555);
      rd(A_RUN, v); check("R3 interrupted stop", v, 1);
    end
    wr(A_KEY, 32'h1234AAAA); wr(A_KEY, 32'hFFFF5555);
    rd(A_RUN, v); check("R2 stop", v, 0);

    // R8 trigger reload, R4 plain counting
    wr(A_CTRL, 32'h0);
    wr(A_LOAD, 32'h10);
    fire_trig();
    rd(A_COUNT, v); check("R8 trigger reload", v, 32'h10);
    start_t(); idle(10); stop_t();
    rd(A_COUNT, v); check("R4 count per clock", v, 32'h10 + run_edges(10, 0, 0));
    idle(5);
    rd(A_COUNT, v); check("R4 hold when stopped", v, 32'h10 + run_edges(10, 0, 0));

    // R5 random prescale runs
    for (int i = 0; i < 8; i++) begin
      int ptv = int'($urandom_range(0, 3));
      int n   = int'($urandom_range(4, 70));
      wr(A_CTRL, 32'(2 | (ptv << 2)));
      rd(A_CTRL, v); check("R7 ctrl readback", v, 32'(2 | (ptv << 2)));
      fire_trig();
      start_t(); idle(n); stop_t();
      rd(A_COUNT, v); check("R5 prescaled count", v, 32'h10 + run_edges(n, 1, ptv));
    end

    // R6 overflow, enable off
    wr(A_CTRL, 32'h0);
    wr(A_LOAD, 32'hFFFFFFFD);
    fire_trig();
    start_t(); idle(1); stop_t();
    rd(A_COUNT, v); check("R6 wrap reload", v, 32'hFFFFFFFD);
    rd(A_STAT, v);  check("R6 status set", v, 1);
    check("R9 no irq without enable", 32'(irq_n), 1);

    // R7 staged load used only at wrap
    wr(A_LOAD, 32'h100);
    rd(A_LOAD, v);  check("R7 load readback", v, 32'h100);
    rd(A_COUNT, v); check("R7 count untouched by load write", v, 32'hFFFFFFFD);
    start_t(); idle(3); stop_t();
    rd(A_COUNT, v); check("R7 new load after wrap", v, 32'h102);

    // R9 enable after status
    wr(A_IEN, 32'h1); idle(1);
    check("R9 irq enable-last", 32'(irq_n), 0);
    // R10 write 0 no effect, write-back clears
    wr(A_STAT, 32'h0); idle(1);
    rd(A_STAT, v); check("R10 zero write ignored", v, 1);
    check("R10 irq still low", 32'(irq_n), 0);
    rd(A_STAT, v); wr(A_STAT, v); idle(1);
    rd(A_STAT, v); check("R10 write-back clears", v, 0);
    check("R9 irq released", 32'(irq_n), 1);

    // R9 status after enable
    wr(A_LOAD, 32'hFFFFFFFE);
    fire_trig();
    start_t(); stop_t(); idle(1);
    rd(A_COUNT, v); check("R6 second wrap", v, 32'hFFFFFFFE);
    check("R9 irq status-last", 32'(irq_n), 0);
    wr(A_STAT, 32'h1); idle(1);
    check("R9 irq after ack", 32'(irq_n), 1);

    // R8 same trigger value ignored
    wr(A_LOAD, 32'h50);
    wr(A_TRIG, trig_val);
    rd(A_COUNT, v); check("R8 repeated trigger ignored", v, 32'hFFFFFFFE);
    fire_trig();
    rd(A_COUNT, v); check("R8 new trigger reload", v, 32'h50);

    // R11 freeze under halt
    wr(A_LOAD, 32'h20); fire_trig();
    emu_halt = 1'b1;
    start_t(); idle(10); stop_t();
    rd(A_COUNT, v); check("R11 frozen", v, 32'h20);
    wr(A_CTRL, 32'h20);
    start_t(); idle(10); stop_t();
    rd(A_COUNT, v); check("R11 free-run", v, 32'h20 + run_edges(10, 0, 0));
    emu_halt = 1'b0;

    // R12 read latency: data is present exactly one clock after the strobe
    bus_re = 1'b1; bus_addr = A_LOAD;
    @(negedge clk);
    bus_re = 1'b0;
    check("R12 read data one clock later", bus_rdata, 32'h20);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule